// File: doc/BRIEF.md
# NAND Access Width Serializer

This block sits between a host port and an 8- or 16-bit NAND flash bus. One host access of one, two or four bytes, aimed at the command, address or data window of the NAND device, is broken into the right number of device bus cycles. Each cycle carries the correct slice of the host word. On reads, the slices the device returns are packed back into a 32-bit host result. The command-latch and address-latch enables follow the window that was hit.

Each device cycle is held until the device side acknowledges it. A one-cycle done pulse then closes the access. A device-width select bit picks between 8-bit and 16-bit behaviour. When the chip select's device-type field does not indicate NAND, no bus cycles are made: writes vanish and reads return zero.

Encodings used throughout:
- Window: 0 = command, 1 = address, 2 or 3 = data.
- Size: 0 = byte, 1 = halfword, 2 or 3 = word.
- Device type: NAND is the value 2.

Top module: `nand_width_serializer`

## Requirements
- R1: With `devWide`=0 (8-bit device), a byte access makes 1 device cycle, a halfword 2 and a word 4. Cycle k carries host byte k (least significant first) on `devDout[7:0]`, with `devDout[15:8]`=0.
- R2: With `devWide`=1 (16-bit device), a byte or halfword access makes 1 cycle and a word access makes 2. The low half goes first: cycle k carries host bits [16k+15:16k].
- R3: A byte read from a 16-bit device returns device bits [7:0] in `rdData[7:0]`; `rdData[31:8]` is 0.
- R4: A byte write to a 16-bit device is one 16-bit cycle that drives host bits [15:0] unchanged.
- R5: During a device cycle, window 0 asserts `devCle` only, window 1 asserts `devAle` only, and the data window asserts neither. `devWe` is 1 for writes and 0 for reads. Outside a device cycle, all three are 0.
- R6: If `devType` is not 2 when a request is accepted, no device cycle occurs. `done` pulses on the next cycle and `rdData` reads 0.
- R7: A device cycle, together with its data and latch enables, is held unchanged until `devAck` is seen high on a clock edge.
- R8: `done` is high for the single cycle after the edge that acknowledges the last device cycle, and no device cycle is active while it is high. `rdData` then holds the read bytes little-endian, with every byte that was not read set to 0.
- R9: A request raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWindow | input | 2 | 0 command, 1 address, 2/3 data |
| reqSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| reqWdata | input | 32 | Host write data |
| devWide | input | 1 | Device width: 0 = 8-bit, 1 = 16-bit |
| devType | input | 2 | Chip-select device type; 2 = NAND |
| devAck | input | 1 | Device acknowledge for the current cycle |
| devDin | input | 16 | Device read data |
| devCycle | output | 1 | A device bus cycle is active |
| devWe | output | 1 | The active cycle is a write |
| devCle | output | 1 | Command-latch enable |
| devAle | output | 1 | Address-latch enable |
| devDout | output | 16 | Device write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | Access-complete pulse |
| rdData | output | 32 | Assembled host read data |

## Verification
The tests read and write each access size on both device widths. This separates the per-width cycle counts and shows which slice of the host word lands in each cycle. Distinct per-cycle device data (0x9k3k on cycle k) makes lane mixups and uncleared upper bytes visible in the result. The 16-bit byte read and byte write cases isolate the passthrough of mismatched narrow accesses. The command and address windows are contrasted against the data window. A non-NAND device type, a delayed acknowledge and a request raised mid-access cover the suppression, hold and ignore behaviours.

// File: rtl/nandser_pkg.sv
package nandser_pkg;
  localparam int HOST_W = 32;
  localparam int DEV_W = 16;
  localparam int IDX_W = 2;
  localparam logic [1:0] NAND_TYPE = 2'd2;

  typedef enum logic [1:0] {WIN_CMD = 2'd0, WIN_ADDR = 2'd1, WIN_DATA = 2'd2, WIN_DATA2 = 2'd3} win_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} size_e;

  typedef struct packed {
    logic load;
    logic clear;
    logic step;
    logic active;
    logic [IDX_W-1:0] idx;
  } ctl_t;
endpackage

// File: rtl/nandser_ctrl.sv
module nandser_ctrl
  import nandser_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSize,
  input  logic       devWide,
  input  logic [1:0] devType,
  input  logic       devAck,
  output ctl_t       ctl,
  output logic       busy,
  output logic       done
);
  logic running;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] lastCalc;
  logic accept;
  logic typeOk;
  logic finish;

  always_comb begin
    if (devWide) lastCalc = (reqSize[1]) ? IDX_W'(1) : IDX_W'(0);
    else if (reqSize[1]) lastCalc = IDX_W'(3);
    else if (reqSize[0]) lastCalc = IDX_W'(1);
    else lastCalc = IDX_W'(0);
  end

  assign accept = reqValid && !running;
  assign typeOk = (devType == NAND_TYPE);
  assign finish = running && devAck && (idxQ == lastIdx);

  always_comb begin
    ctl.load   = accept && typeOk;
    ctl.clear  = accept && !typeOk;
    ctl.step   = running && devAck;
    ctl.active = running;
    ctl.idx    = idxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      idxQ    <= '0;
      lastIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish || (accept && !typeOk);
      if (accept && typeOk) begin
        running <= 1'b1;
        idxQ    <= '0;
        lastIdx <= lastCalc;
      end else if (finish) begin
        running <= 1'b0;
      end else if (running && devAck) begin
        idxQ <= idxQ + IDX_W'(1);
      end
    end
  end

  assign busy = running;
endmodule

// File: rtl/nandser_dp.sv
module nandser_dp
  import nandser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              reqWrite,
  input  logic [1:0]        reqWindow,
  input  logic [1:0]        reqSize,
  input  logic [HOST_W-1:0] reqWdata,
  input  logic              devWide,
  input  logic [DEV_W-1:0]  devDin,
  output logic              devCycle,
  output logic              devWe,
  output logic              devCle,
  output logic              devAle,
  output logic [DEV_W-1:0]  devDout,
  output logic [HOST_W-1:0] rdData
);
  localparam int NBYTES = HOST_W / 8;
  localparam int NHALF = HOST_W / DEV_W;

  logic [HOST_W-1:0] wdataQ;
  logic [1:0] sizeQ;
  logic [1:0] winQ;
  logic wideQ;
  logic writeQ;
  logic [7:0] byteLane [NBYTES];
  logic [DEV_W-1:0] halfLane [NHALF];

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_byte
      assign byteLane[g] = wdataQ[g*8 +: 8];
    end
    for (g = 0; g < NHALF; g++) begin : g_half
      assign halfLane[g] = wdataQ[g*DEV_W +: DEV_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdataQ <= '0;
      sizeQ  <= '0;
      winQ   <= '0;
      wideQ  <= 1'b0;
      writeQ <= 1'b0;
      rdData <= '0;
    end else if (ctl.load) begin
      wdataQ <= reqWdata;
      sizeQ  <= reqSize;
      winQ   <= reqWindow;
      wideQ  <= devWide;
      writeQ <= reqWrite;
      rdData <= '0;
    end else if (ctl.clear) begin
      rdData <= '0;
    end else if (ctl.step && !writeQ) begin
      if (wideQ) begin
        if (sizeQ == SZ_BYTE) rdData[7:0] <= devDin[7:0];
        else rdData[ctl.idx[0]*DEV_W +: DEV_W] <= devDin;
      end else begin
        rdData[ctl.idx*8 +: 8] <= devDin[7:0];
      end
    end
  end

  always_comb begin
    devCycle = ctl.active;
    devWe    = ctl.active && writeQ;
    devCle   = ctl.active && (winQ == WIN_CMD);
    devAle   = ctl.active && (winQ == WIN_ADDR);
    if (!ctl.active || !writeQ) devDout = '0;
    else if (wideQ) devDout = halfLane[ctl.idx[0]];
    else devDout = {{(DEV_W-8){1'b0}}, byteLane[ctl.idx]};
  end
endmodule

// File: rtl/nand_width_serializer.sv
module nand_width_serializer
  import nandser_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  reqWindow,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqWdata,
  input  logic        devWide,
  input  logic [1:0]  devType,
  input  logic        devAck,
  input  logic [15:0] devDin,
  output logic        devCycle,
  output logic        devWe,
  output logic        devCle,
  output logic        devAle,
  output logic [15:0] devDout,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdData
);
  ctl_t ctl;

  nandser_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize(reqSize),
    .devWide(devWide), .devType(devType), .devAck(devAck),
    .ctl(ctl), .busy(busy), .done(done)
  );

  nandser_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqWindow(reqWindow), .reqSize(reqSize), .reqWdata(reqWdata),
    .devWide(devWide), .devDin(devDin), .devCycle(devCycle),
    .devWe(devWe), .devCle(devCle), .devAle(devAle),
    .devDout(devDout), .rdData(rdData)
  );
endmodule

// File: rtl/nandser_checker.sv
module nandser_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [1:0]  devType,
  input logic        devAck,
  input logic        devCycle,
  input logic        devCle,
  input logic        devAle,
  input logic        devWe,
  input logic [15:0] devDout,
  input logic        busy,
  input logic        done,
  input logic [31:0] rdData
);
  a_r5_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(devCle && devAle));

  a_r5_latch_in_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (devCle || devAle || devWe) |-> devCycle);

  a_r6_non_nand_skip: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && devType != 2'd2) |=> (done && !devCycle && rdData == 32'd0));

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (devCycle && !devAck) |=> (devCycle && $stable(devDout) && $stable(devCle)
                              && $stable(devAle) && $stable(devWe)));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !devCycle);
endmodule

bind nand_width_serializer nandser_checker u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .devType(devType),
  .devAck(devAck), .devCycle(devCycle), .devCle(devCle), .devAle(devAle),
  .devWe(devWe), .devDout(devDout), .busy(busy), .done(done), .rdData(rdData)
);

// File: tb/nand_width_serializer_bench.sv
module nand_width_serializer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [1:0] reqWindow = 2'd2;
  logic [1:0] reqSize = 2'd0;
  logic [31:0] reqWdata = 32'd0;
  logic devWide = 1'b0;
  logic [1:0] devType = 2'd2;
  logic devAck = 1'b0;
  logic [15:0] devDin = 16'd0;
  logic devCycle, devWe, devCle, devAle, busy, done;
  logic [15:0] devDout;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails = 0;
  int nCyc;
  logic [15:0] recDout [8];
  logic recCle [8];
  logic recAle [8];
  logic recWe [8];

  always #2.5 clk = ~clk;

  nand_width_serializer u_nand_width_serializer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWindow(reqWindow), .reqSize(reqSize), .reqWdata(reqWdata),
    .devWide(devWide), .devType(devType), .devAck(devAck), .devDin(devDin),
    .devCycle(devCycle), .devWe(devWe), .devCle(devCle), .devAle(devAle),
    .devDout(devDout), .busy(busy), .done(done), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs one access; the bench plays the device: cycle k returns 16'h9k3k.
  task automatic doXfer(input logic wr, input logic [1:0] win, input logic [1:0] sz,
                        input logic [31:0] wd, input int ackDelay, input bit inject);
    int waitCnt = 0;
    bit finished = 0;
    logic [15:0] firstDout = 16'd0;
    nCyc = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWindow = win; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    for (int it = 0; it < 60 && !finished; it++) begin
      devAck = 1'b0;
      if (inject && it == 0) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqWindow = 2'd0; reqSize = 2'd2;
      end else begin
        reqValid = 1'b0;
      end
      if (done) begin
        finished = 1;
      end else if (devCycle) begin
        if (waitCnt == 0) firstDout = devDout;
        if (waitCnt < ackDelay) begin
          waitCnt++;
        end else begin
          if (ackDelay > 0) chk("R7 held dout", {16'd0, devDout}, {16'd0, firstDout});
          if (nCyc < 8) begin
            recDout[nCyc] = devDout; recCle[nCyc] = devCle;
            recAle[nCyc] = devAle; recWe[nCyc] = devWe;
          end
          devDin = {4'h9, 4'(nCyc), 4'h3, 4'(nCyc)};
          devAck = 1'b1;
          nCyc++;
          waitCnt = 0;
        end
      end
      if (!finished) @(negedge clk);
    end
    devAck = 1'b0;
    reqValid = 1'b0;
    if (!finished) chk("watchdog access", 32'd0, 32'd1);
  endtask

  task automatic testReset();
    chk("R8 reset done", {31'd0, done}, 32'd0);
    chk("R5 reset cycle", {28'd0, devCycle, devCle, devAle, devWe}, 32'd0);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R8 reset rdData", rdData, 32'd0);
  endtask

  task automatic testNarrowReads();
    devWide = 1'b0;
    doXfer(1'b0, 2'd2, 2'd0, 32'd0, 0, 0);
    chk("R1 8b byte count", nCyc, 1);
    chk("R8 8b byte rd", rdData, 32'h0000_0030);
    doXfer(1'b0, 2'd2, 2'd1, 32'd0, 0, 0);
    chk("R1 8b half count", nCyc, 2);
    chk("R8 8b half rd", rdData, 32'h0000_3130);
    doXfer(1'b0, 2'd2, 2'd2, 32'd0, 0, 0);
    chk("R1 8b word count", nCyc, 4);
    chk("R1 8b word rd", rdData, 32'h3332_3130);
    chk("R5 data read no latch", {29'd0, recCle[0], recAle[0], recWe[0]}, 32'd0);
  endtask

  task automatic testNarrowWrites();
    devWide = 1'b0;
    doXfer(1'b1, 2'd2, 2'd2, 32'hDDCC_BBAA, 0, 0);
    chk("R1 8b word wr count", nCyc, 4);
    chk("R1 8b wr lane0", {16'd0, recDout[0]}, 32'h00AA);
    chk("R1 8b wr lane1", {16'd0, recDout[1]}, 32'h00BB);
    chk("R1 8b wr lane2", {16'd0, recDout[2]}, 32'h00CC);
    chk("R1 8b wr lane3", {16'd0, recDout[3]}, 32'h00DD);
    chk("R5 write we", {31'd0, recWe[3]}, 32'd1);
    doXfer(1'b1, 2'd2, 2'd1, 32'hDDCC_BBAA, 0, 0);
    chk("R1 8b half wr count", nCyc, 2);
    chk("R1 8b half lane1", {16'd0, recDout[1]}, 32'h00BB);
  endtask

  task automatic testWideReads();
    devWide = 1'b1;
    doXfer(1'b0, 2'd2, 2'd2, 32'd0, 0, 0);
    chk("R2 16b word count", nCyc, 2);
    chk("R2 16b word rd", rdData, 32'h9131_9030);
    doXfer(1'b0, 2'd2, 2'd1, 32'd0, 0, 0);
    chk("R2 16b half count", nCyc, 1);
    chk("R8 16b half rd", rdData, 32'h0000_9030);
    doXfer(1'b0, 2'd2, 2'd0, 32'd0, 0, 0);
    chk("R3 16b byte count", nCyc, 1);
    chk("R3 16b byte rd", rdData, 32'h0000_0030);
  endtask

  task automatic testWideWrites();
    devWide = 1'b1;
    doXfer(1'b1, 2'd2, 2'd2, 32'hDDCC_BBAA, 0, 0);
    chk("R2 16b wr count", nCyc, 2);
    chk("R2 16b wr low", {16'd0, recDout[0]}, 32'hBBAA);
    chk("R2 16b wr high", {16'd0, recDout[1]}, 32'hDDCC);
    doXfer(1'b1, 2'd2, 2'd0, 32'hDDCC_BBAA, 0, 0);
    chk("R4 16b byte wr count", nCyc, 1);
    chk("R4 16b byte wr data", {16'd0, recDout[0]}, 32'hBBAA);
  endtask

  task automatic testWindows();
    devWide = 1'b0;
    doXfer(1'b1, 2'd0, 2'd1, 32'h0000_0070, 0, 0);
    chk("R5 cmd cle", {31'd0, recCle[0]}, 32'd1);
    chk("R5 cmd ale", {31'd0, recAle[1]}, 32'd0);
    doXfer(1'b1, 2'd1, 2'd0, 32'h0000_0012, 0, 0);
    chk("R5 addr ale", {31'd0, recAle[0]}, 32'd1);
    chk("R5 addr cle", {31'd0, recCle[0]}, 32'd0);
  endtask

  task automatic testNonNand();
    devWide = 1'b0;
    doXfer(1'b0, 2'd2, 2'd2, 32'd0, 0, 0);
    devType = 2'd0;
    doXfer(1'b0, 2'd2, 2'd2, 32'd0, 0, 0);
    chk("R6 no read cycles", nCyc, 0);
    chk("R6 read zero", rdData, 32'd0);
    doXfer(1'b1, 2'd0, 2'd2, 32'h1234_5678, 0, 0);
    chk("R6 no write cycles", nCyc, 0);
    devType = 2'd2;
  endtask

  task automatic testHoldAndBusy();
    devWide = 1'b0;
    doXfer(1'b0, 2'd2, 2'd0, 32'd0, 3, 1);
    chk("R9 count unchanged", nCyc, 1);
    chk("R9 window unchanged", {30'd0, recCle[0], recWe[0]}, 32'd0);
    chk("R7 delayed rd", rdData, 32'h0000_0030);
    @(negedge clk);
    chk("R9 no extra cycle", {30'd0, devCycle, busy}, 32'd0);
  endtask

  initial begin
    #20000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testNarrowReads();
    testNarrowWrites();
    testWideReads();
    testWideWrites();
    testWindows();
    testNonNand();
    testHoldAndBusy();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule